// File: doc/BRIEF.md
# Single-Transfer Accumulator Datapath

This block is the register-and-memory datapath of a small 8-bit accumulator machine. It holds a program counter, a memory address register, a memory data register, an accumulator, an index register and a stack pointer. It also holds a 256-word storage array. An external sequencer decides which micro-step runs next. It presents a numbered control code together with a valid strobe. On the rising clock edge the block performs exactly that one move, memory access, counter step or ALU operation. An instruction is therefore a short series of such codes.

Two flags, zero and carry, are produced by additions, subtractions and the two compare codes. The compares measure the accumulator or the index register against the memory word at the address register. They change only the flags. Every register and both flags are driven out on ports, so a sequencer or a bench can watch the effect of each step. The storage array is given a known fill pattern on reset. A parameter selects the pattern, so a bench can choose the memory image it starts from.

Top module: `xfer_datapath`

## Requirements
- R1: Reset, synchronous and active high, clears all six registers and both flags to 0. It also loads every storage word at address a with the value a XOR FILL.
- R2: With ctl_valid low, no register, flag or storage word changes, whatever the code.
- R3: The codes 0, 3 and 37 to 63 are unassigned and change no state when strobed.
- R4: Address and storage codes work as follows. 1 copies PC to MAR. 19 copies XR to MAR. 23 copies MDR to MAR. 29 copies SP to MAR. 2 loads MDR from the word at MAR. 22 writes MDR into the word at MAR.
- R5: Move codes work as follows. 5 copies MDR to ACC and 8 copies ACC to MDR. 17 copies MDR to XR and 18 copies XR to MDR. 33 copies MDR to SP and 32 copies SP to MDR. 28 copies MDR to PC and 34 copies PC to XR.
- R6: Step codes count modulo 256. The increments are 4 (PC), 6 (ACC), 20 (XR), 26 (MDR) and 30 (SP). The decrements are 7 (ACC), 21 (XR), 27 (MDR) and 31 (SP).
- R7: Code 9 sets ACC to ACC+MDR modulo 256. It sets carry when the unsigned sum exceeds 255, and sets zero when the 8-bit result is 0.
- R8: Code 10 sets ACC to ACC-MDR modulo 256. It sets carry when no borrow occurs (ACC >= MDR), and sets zero when the 8-bit result is 0.
- R9: Code 11 sets ACC to ACC XOR MDR, code 12 to ACC AND MDR, and code 13 to ACC OR MDR. Code 14 replaces ACC with its bitwise inverse.
- R10: Code 15 shifts ACC left by one and code 16 shifts it right by one. The vacated bit is filled with 0 in both cases.
- R11: Code 24 clears ACC and code 25 clears XR.
- R12: Code 35 evaluates ACC minus the word at MAR, and code 36 evaluates XR minus that word. Each sets zero and carry by the rule of R8 and leaves every register unchanged.
- R13: Codes other than 9, 10, 35 and 36 leave both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ctl_valid | input | 1 | Strobe: perform ctl_code on this edge |
| ctl_code | input | 6 | Numbered micro-step to perform |
| pc_o | output | DATA_W | Program counter |
| mar_o | output | DATA_W | Memory address register |
| mdr_o | output | DATA_W | Memory data register |
| acc_o | output | DATA_W | Accumulator |
| xr_o | output | DATA_W | Index register |
| sp_o | output | DATA_W | Stack pointer |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Carry / no-borrow flag |

## Verification
The bench builds the block with DATA_W at 8, which gives a 256-word array, and with FILL at 8'h5A. Every storage word therefore starts at a known non-zero value that differs from its address. This makes address errors visible on a read. The full 8-bit range lets the index and stack counters wrap between 00 and FF. It also lets an addition overflow and a subtraction borrow with small operands. A second reset in mid-run is then followed by a read of the top word, to show that the fill pattern returns after a write.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

    localparam int XFER_CODE_W = 6;

    typedef enum logic [XFER_CODE_W-1:0] {
        OP_PC_TO_MAR  = 6'd1,
        OP_MEM_RD     = 6'd2,
        OP_PC_INC     = 6'd4,
        OP_MDR_TO_ACC = 6'd5,
        OP_ACC_INC    = 6'd6,
        OP_ACC_DEC    = 6'd7,
        OP_ACC_TO_MDR = 6'd8,
        OP_ADD        = 6'd9,
        OP_SUB        = 6'd10,
        OP_XOR        = 6'd11,
        OP_AND        = 6'd12,
        OP_OR         = 6'd13,
        OP_INV        = 6'd14,
        OP_SHL        = 6'd15,
        OP_SHR        = 6'd16,
        OP_MDR_TO_XR  = 6'd17,
        OP_XR_TO_MDR  = 6'd18,
        OP_XR_TO_MAR  = 6'd19,
        OP_XR_INC     = 6'd20,
        OP_XR_DEC     = 6'd21,
        OP_MEM_WR     = 6'd22,
        OP_MDR_TO_MAR = 6'd23,
        OP_ACC_CLR    = 6'd24,
        OP_XR_CLR     = 6'd25,
        OP_MDR_INC    = 6'd26,
        OP_MDR_DEC    = 6'd27,
        OP_MDR_TO_PC  = 6'd28,
        OP_SP_TO_MAR  = 6'd29,
        OP_SP_INC     = 6'd30,
        OP_SP_DEC     = 6'd31,
        OP_SP_TO_MDR  = 6'd32,
        OP_MDR_TO_SP  = 6'd33,
        OP_PC_TO_XR   = 6'd34,
        OP_CMP_ACC    = 6'd35,
        OP_CMP_XR     = 6'd36
    } xfer_code_e;

    typedef enum logic [2:0] {
        DST_NONE, DST_PC, DST_MAR, DST_MDR, DST_ACC, DST_XR, DST_SP
    } dst_e;

    typedef enum logic [2:0] {
        SRCA_ZERO, SRCA_PC, SRCA_MDR, SRCA_ACC, SRCA_XR, SRCA_SP, SRCA_MEM
    } srca_e;

    typedef enum logic {
        SRCB_MDR, SRCB_MEM
    } srcb_e;

    typedef enum logic [3:0] {
        ALU_PASS, ALU_ADD, ALU_SUB, ALU_XOR, ALU_AND, ALU_OR,
        ALU_INV, ALU_SHL, ALU_SHR, ALU_INC, ALU_DEC
    } alu_op_e;

    typedef struct packed {
        dst_e    dst;
        srca_e   srca;
        srcb_e   srcb;
        alu_op_e op;
        logic    mem_we;
        logic    flag_we;
    } xfer_ctl_t;

    typedef struct packed {
        logic zero;
        logic carry;
    } xfer_flags_t;

    localparam xfer_ctl_t CTL_IDLE = '{
        dst: DST_NONE, srca: SRCA_ZERO, srcb: SRCB_MDR,
        op: ALU_PASS, mem_we: 1'b0, flag_we: 1'b0
    };

    // Build one control word; every decoded step goes through here.
    function automatic xfer_ctl_t mk_ctl(dst_e d, srca_e a, srcb_e b,
                                         alu_op_e o, logic we, logic fw);
        xfer_ctl_t c;
        c.dst     = d;
        c.srca    = a;
        c.srcb    = b;
        c.op      = o;
        c.mem_we  = we;
        c.flag_we = fw;
        return c;
    endfunction

    // A plain register-to-register copy through the ALU pass path.
    function automatic xfer_ctl_t mk_move(dst_e d, srca_e a);
        return mk_ctl(d, a, SRCB_MDR, ALU_PASS, 1'b0, 1'b0);
    endfunction

endpackage

// File: rtl/xfer_decode.sv
module xfer_decode
    import xfer_pkg::*;
(
    input  logic                   ctl_valid,
    input  logic [XFER_CODE_W-1:0] ctl_code,
    output xfer_ctl_t              ctl
);

    always_comb begin
        ctl = CTL_IDLE;
        if (ctl_valid) begin
            case (ctl_code)
                OP_PC_TO_MAR:  ctl = mk_move(DST_MAR, SRCA_PC);
                OP_XR_TO_MAR:  ctl = mk_move(DST_MAR, SRCA_XR);
                OP_MDR_TO_MAR: ctl = mk_move(DST_MAR, SRCA_MDR);
                OP_SP_TO_MAR:  ctl = mk_move(DST_MAR, SRCA_SP);
                OP_MEM_RD:     ctl = mk_move(DST_MDR, SRCA_MEM);
                OP_MEM_WR:     ctl = mk_ctl(DST_NONE, SRCA_MDR, SRCB_MDR, ALU_PASS, 1'b1, 1'b0);
                OP_MDR_TO_ACC: ctl = mk_move(DST_ACC, SRCA_MDR);
                OP_ACC_TO_MDR: ctl = mk_move(DST_MDR, SRCA_ACC);
                OP_MDR_TO_XR:  ctl = mk_move(DST_XR,  SRCA_MDR);
                OP_XR_TO_MDR:  ctl = mk_move(DST_MDR, SRCA_XR);
                OP_MDR_TO_SP:  ctl = mk_move(DST_SP,  SRCA_MDR);
                OP_SP_TO_MDR:  ctl = mk_move(DST_MDR, SRCA_SP);
                OP_MDR_TO_PC:  ctl = mk_move(DST_PC,  SRCA_MDR);
                OP_PC_TO_XR:   ctl = mk_move(DST_XR,  SRCA_PC);
                OP_ACC_CLR:    ctl = mk_move(DST_ACC, SRCA_ZERO);
                OP_XR_CLR:     ctl = mk_move(DST_XR,  SRCA_ZERO);
                OP_PC_INC:     ctl = mk_ctl(DST_PC,  SRCA_PC,  SRCB_MDR, ALU_INC, 1'b0, 1'b0);
                OP_ACC_INC:    ctl = mk_ctl(DST_ACC, SRCA_ACC, SRCB_MDR, ALU_INC, 1'b0, 1'b0);
                OP_ACC_DEC:    ctl = mk_ctl(DST_ACC, SRCA_ACC, SRCB_MDR, ALU_DEC, 1'b0, 1'b0);
                OP_XR_INC:     ctl = mk_ctl(DST_XR,  SRCA_XR,  SRCB_MDR, ALU_INC, 1'b0, 1'b0);
                OP_XR_DEC:     ctl = mk_ctl(DST_XR,  SRCA_XR,  SRCB_MDR, ALU_DEC, 1'b0, 1'b0);
                OP_MDR_INC:    ctl = mk_ctl(DST_MDR, SRCA_MDR, SRCB_MDR, ALU_INC, 1'b0, 1'b0);
                OP_MDR_DEC:    ctl = mk_ctl(DST_MDR, SRCA_MDR, SRCB_MDR, ALU_DEC, 1'b0, 1'b0);
                OP_SP_INC:     ctl = mk_ctl(DST_SP,  SRCA_SP,  SRCB_MDR, ALU_INC, 1'b0, 1'b0);
                OP_SP_DEC:     ctl = mk_ctl(DST_SP,  SRCA_SP,  SRCB_MDR, ALU_DEC, 1'b0, 1'b0);
                OP_ADD:        ctl = mk_ctl(DST_ACC, SRCA_ACC, SRCB_MDR, ALU_ADD, 1'b0, 1'b1);
                OP_SUB:        ctl = mk_ctl(DST_ACC, SRCA_ACC, SRCB_MDR, ALU_SUB, 1'b0, 1'b1);
                OP_XOR:        ctl = mk_ctl(DST_ACC, SRCA_ACC, SRCB_MDR, ALU_XOR, 1'b0, 1'b0);
                OP_AND:        ctl = mk_ctl(DST_ACC, SRCA_ACC, SRCB_MDR, ALU_AND, 1'b0, 1'b0);
                OP_OR:         ctl = mk_ctl(DST_ACC, SRCA_ACC, SRCB_MDR, ALU_OR,  1'b0, 1'b0);
                OP_INV:        ctl = mk_ctl(DST_ACC, SRCA_ACC, SRCB_MDR, ALU_INV, 1'b0, 1'b0);
                OP_SHL:        ctl = mk_ctl(DST_ACC, SRCA_ACC, SRCB_MDR, ALU_SHL, 1'b0, 1'b0);
                OP_SHR:        ctl = mk_ctl(DST_ACC, SRCA_ACC, SRCB_MDR, ALU_SHR, 1'b0, 1'b0);
                OP_CMP_ACC:    ctl = mk_ctl(DST_NONE, SRCA_ACC, SRCB_MEM, ALU_SUB, 1'b0, 1'b1);
                OP_CMP_XR:     ctl = mk_ctl(DST_NONE, SRCA_XR,  SRCB_MEM, ALU_SUB, 1'b0, 1'b1);
                default:       ctl = CTL_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/xfer_alu.sv
module xfer_alu
    import xfer_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] res,
    output xfer_flags_t       flags
);

    localparam int EXT_W = DATA_W + 1;
    localparam logic [EXT_W-1:0] ONE_X = EXT_W'(1);

    logic [EXT_W-1:0] a_x;
    logic [EXT_W-1:0] b_x;
    logic [EXT_W-1:0] ext;

    assign a_x = {1'b0, opa};
    assign b_x = {1'b0, opb};

    always_comb begin
        case (op)
            ALU_ADD: ext = a_x + b_x;
            ALU_SUB: ext = a_x - b_x;
            ALU_XOR: ext = a_x ^ b_x;
            ALU_AND: ext = a_x & b_x;
            ALU_OR:  ext = a_x | b_x;
            ALU_INV: ext = {1'b0, ~opa};
            ALU_SHL: ext = {1'b0, opa[DATA_W-2:0], 1'b0};
            ALU_SHR: ext = {2'b00, opa[DATA_W-1:1]};
            ALU_INC: ext = a_x + ONE_X;
            ALU_DEC: ext = a_x - ONE_X;
            default: ext = a_x;
        endcase
    end

    assign res = ext[DATA_W-1:0];

    always_comb begin
        flags.zero = (res == '0);
        case (op)
            ALU_ADD: flags.carry = ext[DATA_W];
            ALU_SUB: flags.carry = ~ext[DATA_W];
            default: flags.carry = 1'b0;
        endcase
    end

endmodule

// File: rtl/xfer_mem.sv
module xfer_mem #(
    parameter int                DATA_W = 8,
    parameter logic [DATA_W-1:0] FILL   = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << DATA_W;

    logic [DATA_W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                words[i] <= DATA_W'(i) ^ FILL;
            end
        end else if (we) begin
            words[addr] <= wdata;
        end
    end

    assign rdata = words[addr];

endmodule

// File: rtl/xfer_datapath.sv
module xfer_datapath
    import xfer_pkg::*;
#(
    parameter int                DATA_W = 8,
    parameter logic [DATA_W-1:0] FILL   = '0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ctl_valid,
    input  logic [XFER_CODE_W-1:0] ctl_code,
    output logic [DATA_W-1:0]      pc_o,
    output logic [DATA_W-1:0]      mar_o,
    output logic [DATA_W-1:0]      mdr_o,
    output logic [DATA_W-1:0]      acc_o,
    output logic [DATA_W-1:0]      xr_o,
    output logic [DATA_W-1:0]      sp_o,
    output logic                   zero_o,
    output logic                   carry_o
);

    xfer_ctl_t         ctl;
    xfer_flags_t       alu_flags;
    xfer_flags_t       flags_q;
    logic [DATA_W-1:0] pc_q, mar_q, mdr_q, acc_q, xr_q, sp_q;
    logic [DATA_W-1:0] mem_rdata;
    logic [DATA_W-1:0] opa, opb, alu_res;

    xfer_decode u_decode (
        .ctl_valid (ctl_valid),
        .ctl_code  (ctl_code),
        .ctl       (ctl)
    );

    xfer_mem #(
        .DATA_W (DATA_W),
        .FILL   (FILL)
    ) u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (ctl.mem_we),
        .addr  (mar_q),
        .wdata (mdr_q),
        .rdata (mem_rdata)
    );

    // Operand selection for the shared ALU.
    always_comb begin
        case (ctl.srca)
            SRCA_PC:  opa = pc_q;
            SRCA_MDR: opa = mdr_q;
            SRCA_ACC: opa = acc_q;
            SRCA_XR:  opa = xr_q;
            SRCA_SP:  opa = sp_q;
            SRCA_MEM: opa = mem_rdata;
            default:  opa = '0;
        endcase
        opb = (ctl.srcb == SRCB_MEM) ? mem_rdata : mdr_q;
    end

    xfer_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .op    (ctl.op),
        .opa   (opa),
        .opb   (opb),
        .res   (alu_res),
        .flags (alu_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= '0;
            mar_q   <= '0;
            mdr_q   <= '0;
            acc_q   <= '0;
            xr_q    <= '0;
            sp_q    <= '0;
            flags_q <= '0;
        end else begin
            case (ctl.dst)
                DST_PC:  pc_q  <= alu_res;
                DST_MAR: mar_q <= alu_res;
                DST_MDR: mdr_q <= alu_res;
                DST_ACC: acc_q <= alu_res;
                DST_XR:  xr_q  <= alu_res;
                DST_SP:  sp_q  <= alu_res;
                default: ;
            endcase
            if (ctl.flag_we) begin
                flags_q <= alu_flags;
            end
        end
    end

    assign pc_o    = pc_q;
    assign mar_o   = mar_q;
    assign mdr_o   = mdr_q;
    assign acc_o   = acc_q;
    assign xr_o    = xr_q;
    assign sp_o    = sp_q;
    assign zero_o  = flags_q.zero;
    assign carry_o = flags_q.carry;

endmodule

// File: rtl/xfer_datapath_chk.sv
module xfer_datapath_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ctl_valid,
    input logic [5:0]        ctl_code,
    input logic [DATA_W-1:0] pc_o,
    input logic [DATA_W-1:0] mar_o,
    input logic [DATA_W-1:0] mdr_o,
    input logic [DATA_W-1:0] acc_o,
    input logic [DATA_W-1:0] xr_o,
    input logic [DATA_W-1:0] sp_o,
    input logic              zero_o,
    input logic              carry_o
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic unassigned;
    logic flag_code;
    assign unassigned = (ctl_code == 6'd0) || (ctl_code == 6'd3) || (ctl_code > 6'd36);
    assign flag_code  = (ctl_code == 6'd9) || (ctl_code == 6'd10) ||
                        (ctl_code == 6'd35) || (ctl_code == 6'd36);

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !ctl_valid |=> $stable(pc_o) && $stable(mar_o) && $stable(mdr_o) &&
                       $stable(acc_o) && $stable(xr_o) && $stable(sp_o) &&
                       $stable(zero_o) && $stable(carry_o));

    a_r3_unassigned_hold: assert property (@(posedge clk) disable iff (rst)
        ctl_valid && unassigned |=> $stable(pc_o) && $stable(mar_o) && $stable(mdr_o) &&
                                    $stable(acc_o) && $stable(xr_o) && $stable(sp_o) &&
                                    $stable(zero_o) && $stable(carry_o));

    a_r4_mar_from_pc: assert property (@(posedge clk) disable iff (rst)
        ctl_valid && ctl_code == 6'd1 |=> mar_o == $past(pc_o));

    a_r6_pc_step: assert property (@(posedge clk) disable iff (rst)
        ctl_valid && ctl_code == 6'd4 |=> pc_o == $past(pc_o) + ONE);

    a_r11_acc_clear: assert property (@(posedge clk) disable iff (rst)
        ctl_valid && ctl_code == 6'd24 |=> acc_o == '0);

    a_r12_cmp_regs_hold: assert property (@(posedge clk) disable iff (rst)
        ctl_valid && (ctl_code == 6'd35 || ctl_code == 6'd36)
        |=> $stable(pc_o) && $stable(mar_o) && $stable(mdr_o) &&
            $stable(acc_o) && $stable(xr_o) && $stable(sp_o));

    a_r13_flags_hold: assert property (@(posedge clk) disable iff (rst)
        ctl_valid && !flag_code |=> $stable(zero_o) && $stable(carry_o));

endmodule

bind xfer_datapath xfer_datapath_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctl_valid (ctl_valid),
    .ctl_code  (ctl_code),
    .pc_o      (pc_o),
    .mar_o     (mar_o),
    .mdr_o     (mdr_o),
    .acc_o     (acc_o),
    .xr_o      (xr_o),
    .sp_o      (sp_o),
    .zero_o    (zero_o),
    .carry_o   (carry_o)
);

// File: tb/xfer_datapath_bench.sv
`timescale 1ns/1ps
module xfer_datapath_bench;

    localparam int          DATA_W = 8;
    localparam logic [7:0]  FILL   = 8'h5A;

    localparam logic [2:0] S_PC  = 3'd0;
    localparam logic [2:0] S_MAR = 3'd1;
    localparam logic [2:0] S_MDR = 3'd2;
    localparam logic [2:0] S_ACC = 3'd3;
    localparam logic [2:0] S_XR  = 3'd4;
    localparam logic [2:0] S_SP  = 3'd5;
    localparam logic [2:0] S_FLG = 3'd6;   // value {6'b0, zero, carry}

    localparam int NVEC = 48;
    // {code, observed output, expected value, requirement number}
    localparam logic [20:0] VEC [NVEC] = '{
        {6'd2,  S_MDR, 8'h5A, 4'd1},   // R1 fill word 0 = 0^5A
        {6'd5,  S_ACC, 8'h5A, 4'd5},   // R5
        {6'd4,  S_PC,  8'h01, 4'd6},   // R6
        {6'd1,  S_MAR, 8'h01, 4'd4},   // R4
        {6'd2,  S_MDR, 8'h5B, 4'd4},   // R4
        {6'd9,  S_ACC, 8'hB5, 4'd7},   // R7
        {6'd9,  S_FLG, 8'h01, 4'd7},   // R7 overflow: 10, carry
        {6'd10, S_ACC, 8'hB5, 4'd8},   // R8 borrow
        {6'd10, S_FLG, 8'h01, 4'd8},   // R8 B5-5B=5A no borrow
        {6'd23, S_MAR, 8'h5B, 4'd4},   // R4
        {6'd2,  S_MDR, 8'h01, 4'd4},   // R4
        {6'd11, S_ACC, 8'h5B, 4'd9},   // R9
        {6'd12, S_ACC, 8'h01, 4'd9},   // R9
        {6'd26, S_MDR, 8'h02, 4'd6},   // R6
        {6'd13, S_ACC, 8'h03, 4'd9},   // R9
        {6'd14, S_ACC, 8'hFC, 4'd9},   // R9
        {6'd15, S_ACC, 8'hF8, 4'd10},  // R10
        {6'd16, S_ACC, 8'h7C, 4'd10},  // R10
        {6'd17, S_XR,  8'h02, 4'd5},   // R5
        {6'd21, S_XR,  8'h01, 4'd6},   // R6
        {6'd21, S_XR,  8'h00, 4'd6},   // R6
        {6'd21, S_XR,  8'hFF, 4'd6},   // R6 wrap down
        {6'd20, S_XR,  8'h00, 4'd6},   // R6 wrap up
        {6'd31, S_SP,  8'hFF, 4'd6},   // R6
        {6'd29, S_MAR, 8'hFF, 4'd4},   // R4
        {6'd8,  S_MDR, 8'h7C, 4'd5},   // R5
        {6'd22, S_MAR, 8'hFF, 4'd4},   // R4 write
        {6'd27, S_MDR, 8'h7B, 4'd6},   // R6
        {6'd2,  S_MDR, 8'h7C, 4'd4},   // R4 read back written word
        {6'd35, S_FLG, 8'h03, 4'd12},  // R12 equal: zero, carry
        {6'd36, S_FLG, 8'h00, 4'd12},  // R12 00-7C borrow
        {6'd18, S_MDR, 8'h00, 4'd5},   // R5
        {6'd33, S_SP,  8'h00, 4'd5},   // R5
        {6'd30, S_SP,  8'h01, 4'd6},   // R6
        {6'd32, S_MDR, 8'h01, 4'd5},   // R5
        {6'd26, S_MDR, 8'h02, 4'd6},   // R6
        {6'd28, S_PC,  8'h02, 4'd5},   // R5
        {6'd34, S_XR,  8'h02, 4'd5},   // R5
        {6'd19, S_MAR, 8'h02, 4'd4},   // R4
        {6'd24, S_ACC, 8'h00, 4'd11},  // R11
        {6'd25, S_XR,  8'h00, 4'd11},  // R11
        {6'd6,  S_ACC, 8'h01, 4'd6},   // R6
        {6'd7,  S_ACC, 8'h00, 4'd6},   // R6
        {6'd7,  S_ACC, 8'hFF, 4'd6},   // R6 wrap
        {6'd3,  S_ACC, 8'hFF, 4'd3},   // R3
        {6'd0,  S_MDR, 8'h02, 4'd3},   // R3
        {6'd63, S_PC,  8'h02, 4'd3},   // R3
        {6'd37, S_SP,  8'h01, 4'd3}    // R3
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_valid = 1'b0;
    logic [5:0] ctl_code = '0;
    logic [7:0] pc_o, mar_o, mdr_o, acc_o, xr_o, sp_o;
    logic       zero_o, carry_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    xfer_datapath #(
        .DATA_W (DATA_W),
        .FILL   (FILL)
    ) u_xfer_datapath (
        .clk       (clk),
        .rst       (rst),
        .ctl_valid (ctl_valid),
        .ctl_code  (ctl_code),
        .pc_o      (pc_o),
        .mar_o     (mar_o),
        .mdr_o     (mdr_o),
        .acc_o     (acc_o),
        .xr_o      (xr_o),
        .sp_o      (sp_o),
        .zero_o    (zero_o),
        .carry_o   (carry_o)
    );

    function automatic logic [7:0] observe(logic [2:0] sel);
        case (sel)
            S_PC:    return pc_o;
            S_MAR:   return mar_o;
            S_MDR:   return mdr_o;
            S_ACC:   return acc_o;
            S_XR:    return xr_o;
            S_SP:    return sp_o;
            default: return {6'b0, zero_o, carry_o};
        endcase
    endfunction

    task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    // Called at a falling edge; performs one strobed step and returns at the next falling edge.
    task automatic step(logic [5:0] code);
        ctl_code  = code;
        ctl_valid = 1'b1;
        @(negedge clk);
        ctl_valid = 1'b0;
    endtask

    task automatic check_all_clear(string req);
        check(req, "pc",    pc_o,  8'h00);
        check(req, "mar",   mar_o, 8'h00);
        check(req, "mdr",   mdr_o, 8'h00);
        check(req, "acc",   acc_o, 8'h00);
        check(req, "xr",    xr_o,  8'h00);
        check(req, "sp",    sp_o,  8'h00);
        check(req, "flags", {6'b0, zero_o, carry_o}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_all_clear("R1");

        for (int i = 0; i < NVEC; i++) begin
            logic [5:0] code;
            logic [2:0] sel;
            logic [7:0] exp;
            logic [3:0] req;
            {code, sel, exp, req} = VEC[i];
            step(code);
            checks++;
            if (observe(sel) !== exp) begin
                failures++;
                $display("FAIL R%0d vector %0d code %0d: actual=%02h expected=%02h",
                         req, i, code, observe(sel), exp);
            end
        end

        // R2: strobe low with a valid-looking code leaves PC alone.
        ctl_code  = 6'd4;
        ctl_valid = 1'b0;
        @(negedge clk);
        check("R2", "pc idle", pc_o, 8'h02);

        // R12: compare FF against word 02 (02^5A=58): carry set, zero clear, ACC kept.
        step(6'd35);
        check("R12", "cmp flags", {6'b0, zero_o, carry_o}, 8'h01);
        check("R12", "acc kept", acc_o, 8'hFF);
        check("R12", "mdr kept", mdr_o, 8'h02);

        // R13: a non-flag step leaves flags as the compare set them.
        step(6'd4);
        check("R6", "pc inc", pc_o, 8'h03);
        check("R13", "flags hold", {6'b0, zero_o, carry_o}, 8'h01);

        // R1: mid-run reset clears registers and restores fill at the written top word.
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_all_clear("R1");
        step(6'd31);
        step(6'd29);
        step(6'd2);
        check("R1", "refill word FF", mdr_o, 8'hA5);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule